// File: doc/BRIEF.md
# Polled and Interrupt-Capable Keyboard Input Port

This block sits on a simple processor read/write bus and presents a keyboard-like byte source to software as two byte-wide registers at fixed decoded addresses. A one-cycle strobe with a byte stands in for the device. Each new byte is captured into a character register, and a flag in a status register tells software that a character is waiting.

Software can work in either of two ways. It can poll the status register until the ready flag is set, or it can set an enable bit so that an interrupt request line rises whenever a character is pending. Reading the character register consumes the character: the ready flag, the pending-interrupt flag and the overrun flag all clear on that read. If the device delivers a second byte before software has read the first, the newer byte replaces the older one and an overrun flag records the loss.

Reset is an active-low asynchronous input. Inside the block it asserts at once and releases in step with the clock.

Top module: `keyin_port`

## Requirements
- R1: After reset the character register holds 0, the ready, pending-interrupt, enable and overrun flags are 0, and `irq` is low.
- R2: A read (`bus_sel`=1, `bus_we`=0) at address 5000 returns the held character on `bus_rdata` in the same cycle.
- R3: A read at address 5002 returns the status byte: bit 0 ready, bit 1 pending-interrupt, bit 2 interrupt enable, bit 3 overrun, bits 7..4 zero.
- R4: A cycle with `kb_stb`=1 loads `kb_byte` into the character register and sets ready and pending-interrupt, all visible from the next cycle.
- R5: `irq` is high exactly when the pending-interrupt flag and the interrupt enable are both set.
- R6: A read at address 5000 with no strobe in the same cycle clears ready, pending-interrupt and overrun from the next cycle, and leaves the character value unchanged.
- R7: A write (`bus_sel`=1, `bus_we`=1) at 5002 loads the interrupt enable from `bus_wdata` bit 2. The other bits of that write, and any write to 5000, change nothing.
- R8: A strobe while ready is set, with no data read in the same cycle, overwrites the character and sets overrun.
- R9: A strobe in the same cycle as a data read loads the new byte and sets ready and pending-interrupt. Overrun is left clear, and `bus_rdata` shows the old byte during that cycle.
- R10: `bus_rdata` is 0 when `bus_sel` is low or the address is neither 5000 nor 5002, and reads or writes at any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| kb_stb | input | 1 | New byte from device this cycle |
| kb_byte | input | 8 | Byte from device |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check that a strobe loads the byte and sets ready, that a consuming read clears the flags, that a strobe meeting a held character raises overrun, that the character and the enable hold when nothing loads them, and that `irq` is never high without a pending character. Only the bench scenarios can show the exact status bit positions, the interaction of a read and a strobe in the same cycle, and whether upper write bits are ignored. The bench also shows that addresses next to the two decoded ones read zero and leave the state alone. To cover these, it sweeps every byte value through the port with the enable toggling from the same values. It also sweeps write values into both registers and the addresses around the two decoded ones.

// File: rtl/keyin_pkg.sv
package keyin_pkg;
  // status bit positions (software decodes these)
  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_PEND  = 1;
  localparam int unsigned ST_IEN   = 2;
  localparam int unsigned ST_OVR   = 3;
  localparam int unsigned ST_USED  = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CHAR = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic ovr;
    logic ien;
    logic pend;
    logic ready;
  } stat_t;
endpackage

// File: rtl/keyin_rst_sync.sv
module keyin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/keyin_decode.sv
module keyin_decode
  import keyin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CHAR_ADDR = 5000,
  parameter int unsigned STAT_ADDR = 5002
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          rd_sel,
  output logic              char_consume,
  output logic              stat_write
);
  localparam logic [ADDR_W-1:0] CHAR_A = ADDR_W'(CHAR_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic hit_char;
  logic hit_stat;

  always_comb begin
    hit_char     = bus_sel && (bus_addr == CHAR_A);
    hit_stat     = bus_sel && (bus_addr == STAT_A);
    char_consume = hit_char && !bus_we;
    stat_write   = hit_stat && bus_we;
    if (hit_char && !bus_we)      rd_sel = SEL_CHAR;
    else if (hit_stat && !bus_we) rd_sel = SEL_STAT;
    else                          rd_sel = SEL_NONE;
  end
endmodule

// File: rtl/keyin_capture.sv
module keyin_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              consume,
  output logic [DATA_W-1:0] char_q,
  output logic              ready_q,
  output logic              pend_q,
  output logic              ovr_q
);
  logic [DATA_W-1:0] char_d;
  logic              ready_d;
  logic              pend_d;
  logic              ovr_d;
  logic              char_en;
  logic              flag_en;

  // next state
  always_comb begin
    char_en = in_stb;
    flag_en = in_stb | consume;
    char_d  = in_byte;
    ready_d = ready_q;
    pend_d  = pend_q;
    ovr_d   = ovr_q;
    if (in_stb) begin
      ready_d = 1'b1;
      pend_d  = 1'b1;
      // a same-cycle read takes the old byte, so nothing is lost
      ovr_d   = consume ? 1'b0 : (ovr_q | ready_q);
    end else if (consume) begin
      ready_d = 1'b0;
      pend_d  = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
    end else if (char_en) begin
      char_q <= char_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (flag_en) begin
      ready_q <= ready_d;
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
    end
  end

  p_strobe_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> (ready_q && pend_q && char_q == $past(in_byte)));

  p_consume_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !in_stb) |=> (!ready_q && !pend_q && !ovr_q));

  p_char_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> $stable(char_q));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && ready_q && !consume) |=> ovr_q);

  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && consume) |=> (ready_q && !ovr_q));
endmodule

// File: rtl/keyin_ctrl.sv
module keyin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic ien_q
);
  logic ien_d;

  always_comb ien_d = wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ien_q <= 1'b0;
    else if (wr_en) ien_q <= ien_d;
  end

  p_ien_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ien_q));

  p_ien_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ien_q == $past(wr_bit)));
endmodule

// File: rtl/keyin_port.sv
module keyin_port
  import keyin_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CHAR_ADDR  = 5000,
  parameter int unsigned STAT_ADDR  = 5002,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_stb,
  input  logic [DATA_W-1:0] kb_byte,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - ST_USED;

  logic              rst_n;
  reg_sel_e          rd_sel;
  logic              char_consume;
  logic              stat_write;
  logic [DATA_W-1:0] char_q;
  stat_t             stat;

  keyin_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  keyin_decode #(
    .ADDR_W    (ADDR_W),
    .CHAR_ADDR (CHAR_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_dec (
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .rd_sel       (rd_sel),
    .char_consume (char_consume),
    .stat_write   (stat_write)
  );

  keyin_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_stb  (kb_stb),
    .in_byte (kb_byte),
    .consume (char_consume),
    .char_q  (char_q),
    .ready_q (stat.ready),
    .pend_q  (stat.pend),
    .ovr_q   (stat.ovr)
  );

  keyin_ctrl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (stat_write),
    .wr_bit (bus_wdata[ST_IEN]),
    .ien_q  (stat.ien)
  );

  always_comb begin
    case (rd_sel)
      SEL_CHAR: bus_rdata = char_q;
      SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = stat.pend & stat.ien;

  p_irq_needs_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat.ready);

  p_idle_bus_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/keyin_port_test.sv
module keyin_port_test;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        kb_stb = 1'b0;
  logic [7:0]  kb_byte = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_CHAR = 16'd5000;
  localparam logic [15:0] A_STAT = 16'd5002;

  always #10 clk = ~clk;

  keyin_port uut (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_stb(kb_stb), .kb_byte(kb_byte), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    kb_stb = 1'b1; kb_byte = b;
    @(posedge clk); #1;
    kb_stb = 1'b0;
  endtask

  function automatic int stat_exp(bit rdy, bit pend, bit ien, bit ovr);
    return {ovr, ien, pend, rdy};
  endfunction

  initial begin
    logic [7:0] d;
    bit ie;
    repeat (3) @(posedge clk);
    arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_CHAR, d); chk("R1 char", d, 0);
    @(negedge clk); #1 chk("R10 idle rdata", bus_rdata, 0);

    // sweep every byte, enable from write value bit 2, junk upper bits
    ie = 1'b0;
    for (int b = 0; b < 256; b++) begin
      wr(A_STAT, 8'(b));                        // R7
      ie = b[2];
      rd(A_STAT, d); chk("R7 ien only", d, stat_exp(0, 0, ie, 0));
      push(8'(b));                              // R4
      chk("R5 irq set", irq, ie);
      rd(A_STAT, d); chk("R3 status", d, stat_exp(1, 1, ie, 0));
      wr(A_CHAR, ~8'(b));                       // R7 write ignored
      rd(A_CHAR, d); chk("R2 char", d, b);      // consumes (R6)
      chk("R5 irq clear", irq, 0);
      rd(A_STAT, d); chk("R6 cleared", d, stat_exp(0, 0, ie, 0));
      rd(A_CHAR, d); chk("R6 char kept", d, b);
    end

    // R5: pending before enable
    wr(A_STAT, 8'h00);
    push(8'h41);
    chk("R5 irq off", irq, 0);
    wr(A_STAT, 8'h04);
    chk("R5 irq late enable", irq, 1);

    // R8 overrun
    push(8'h42);
    rd(A_STAT, d); chk("R8 overrun", d, stat_exp(1, 1, 1, 1));
    rd(A_CHAR, d); chk("R8 newest byte", d, 8'h42);
    rd(A_STAT, d); chk("R6 overrun cleared", d, stat_exp(0, 0, 1, 0));

    // R9 strobe and read in the same cycle
    push(8'h55);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_CHAR;
    kb_stb = 1'b1; kb_byte = 8'hAA;
    #2 chk("R9 old byte read", bus_rdata, 8'h55);
    @(posedge clk); #1;
    bus_sel = 1'b0; kb_stb = 1'b0;
    chk("R9 irq", irq, 1);
    rd(A_STAT, d); chk("R9 status", d, stat_exp(1, 1, 1, 0));
    rd(A_CHAR, d); chk("R9 new byte", d, 8'hAA);

    // R10 neighbouring addresses: read zero, no effect
    push(8'h33);
    for (int a = 4990; a <= 5012; a++) begin
      if (a == 5000 || a == 5002) continue;
      rd(16'(a), d); chk("R10 other read", d, 0);
      wr(16'(a), 8'h00);
    end
    rd(A_STAT, d); chk("R10 state kept", d, stat_exp(1, 1, 1, 0));
    rd(A_CHAR, d); chk("R10 char kept", d, 8'h33);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule